// File: doc/BRIEF.md
# Register Context Save/Restore Sequencer

This block saves and reloads the working context of an arithmetic unit. A stop request loads a 16-bit save-address register from the `aData` input. The block then waits until the arithmetic operation in progress has finished. After that it writes the unit's registers to consecutive memory words through a word-wide DMA port that uses a request/acknowledge handshake. A restart request loads the same register and reads the record back. Each word returned is handed to the owning register through a load strobe, a word selector and a data bus.

The record keeps the same order in both directions. It starts with the status word captured when the stop was accepted, followed by the command word, the index word and the program count. The accumulator follows, least significant word first. The top accumulator word is included only in double-precision mode. When a restore ends, a resume pulse is issued only if the restored status word marks the unit as active. A program clear abandons either sequence at once.

Top module: `ctxSaveSeq`

## Requirements
- R1: A stop accepted while idle loads the save address from `aData`. No memory request is raised while `arithBusy` is high, and the save starts once `arithBusy` is low.
- R2: A save writes, at offsets from the save address: +0 status, +1 command, +2 index, +3 program count, +4 accumulator bits 15..0, +5 bits 31..16.
- R3: Offset +6 (accumulator bits 47..32) is written only when bit 7 of the captured status word (the double-precision bit) is 1. Otherwise the save stops at six words.
- R4: The status word written at +0 equals `statusIn` in the cycle the stop was accepted, with bit 15 (active) and bit 4 (protect) unchanged.
- R5: `seqBusy` is 0 after reset. It is 1 from the cycle after an accepted stop or restart until the final word is acknowledged, including a stop accepted while the unit is idle. It is 0 afterwards.
- R6: `memReq`, `memAddr` and the direction hold steady until `memGnt`. A word counts only when it is acknowledged, and the address rises by one after each acknowledge.
- R7: A restart loads the save address from `aData` and reads from the same offsets. On each acknowledge `ldEn` is 1, `ldSel` gives the offset (0 status … 6 top accumulator word), and `ldData` equals `memRData`.
- R8: A restore reads seven words when bit 7 of the restored status word is 1, and six words otherwise.
- R9: `resumeExec` pulses once, together with the final restore strobe, if bit 15 of the restored status word is 1. Otherwise it stays 0.
- R10: `progClr` ends any save or restore. In the following cycle `seqBusy` and `memReq` are 0, and no further `ldEn` strobe follows.
- R11: Stop and restart requests made while a sequence is running are ignored. They do not change the addresses, the word count or the direction of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopReq | input | 1 | Stop request, one cycle |
| restartReq | input | 1 | Restart request, one cycle |
| progClr | input | 1 | Program clear, aborts a sequence |
| aData | input | 16 | Save address supplied with a request |
| arithBusy | input | 1 | Arithmetic operation in progress |
| statusIn | input | 16 | Live status word |
| cmdIn | input | 16 | Live command word |
| indexIn | input | 16 | Live index word |
| pcIn | input | 16 | Live program count |
| accIn | input | 48 | Live accumulator |
| memReq | output | 1 | DMA word request |
| memWrite | output | 1 | 1 for write, 0 for read |
| memAddr | output | 16 | DMA word address |
| memWData | output | 16 | DMA write data |
| memGnt | input | 1 | DMA acknowledge |
| memRData | input | 16 | DMA read data, valid with acknowledge |
| ldEn | output | 1 | Register load strobe |
| ldSel | output | 3 | Record offset of the word being loaded |
| ldData | output | 16 | Word to load |
| resumeExec | output | 1 | Resume pulse after restore |
| seqBusy | output | 1 | Sequence active |

## Verification
The bench holds `arithBusy` high across several cycles after a stop. A design that starts writing early would save an accumulator that has not settled yet. It runs saves and restores with the double-precision bit both set and clear. A wrong record length would leave a stale word behind, or overrun into the next record, and would also move the resume pulse. It injects slow acknowledges, a program clear in the middle of a restore, and requests issued during a busy sequence. A design that advances without an acknowledge would skip words. A design that fails to abort would keep strobing loads. A design that accepts requests while busy would jump to a different record.

// File: rtl/ctxSavePkg.sv
package ctxSavePkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SAVE, ST_LOAD} seqStateT;

  typedef struct packed {
    logic loadBase;
    logic snapStat;
    logic step;
    logic capHead;
  } dpCtlT;
endpackage

// File: rtl/ctxSaveData.sv
module ctxSaveData
  import ctxSavePkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int HEAD_WORDS = 4,
  parameter int ACC_WORDS = 3,
  parameter int DP_BIT = 7,
  parameter int ACT_BIT = 15,
  parameter int IDXW = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtlT                   ctl,
  input  logic [AW-1:0]           aData,
  input  logic [DW-1:0]           statusIn,
  input  logic [DW-1:0]           cmdIn,
  input  logic [DW-1:0]           indexIn,
  input  logic [DW-1:0]           pcIn,
  input  logic [DW*ACC_WORDS-1:0] accIn,
  input  logic [DW-1:0]           memRData,
  output logic [AW-1:0]           memAddr,
  output logic [DW-1:0]           memWData,
  output logic [IDXW-1:0]         wordIdx,
  output logic                    snapDp,
  output logic                    restDp,
  output logic                    restAct
);
  logic [DW-1:0] statSnap;
  logic [DW-1:0] accWord [ACC_WORDS];

  for (genvar g = 0; g < ACC_WORDS; g++) begin : g_acc
    assign accWord[g] = accIn[g*DW +: DW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      wordIdx  <= '0;
      statSnap <= '0;
      restDp   <= 1'b0;
      restAct  <= 1'b0;
    end else begin
      if (ctl.loadBase) begin
        memAddr <= aData;
        wordIdx <= '0;
      end else if (ctl.step) begin
        memAddr <= memAddr + 1'b1;
        wordIdx <= wordIdx + 1'b1;
      end
      if (ctl.snapStat) statSnap <= statusIn;
      if (ctl.capHead) begin
        restDp  <= memRData[DP_BIT];
        restAct <= memRData[ACT_BIT];
      end
    end
  end

  assign snapDp = statSnap[DP_BIT];

  always_comb begin
    memWData = statSnap;
    if (wordIdx == IDXW'(1)) memWData = cmdIn;
    if (wordIdx == IDXW'(2)) memWData = indexIn;
    if (wordIdx == IDXW'(3)) memWData = pcIn;
    for (int k = 0; k < ACC_WORDS; k++) begin
      if (wordIdx == IDXW'(HEAD_WORDS + k)) memWData = accWord[k];
    end
  end
endmodule

// File: rtl/ctxSaveCtl.sv
module ctxSaveCtl
  import ctxSavePkg::*;
#(
  parameter int IDXW = 3,
  parameter int LAST_SP = 5,
  parameter int LAST_DP = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stopReq,
  input  logic            restartReq,
  input  logic            progClr,
  input  logic            arithBusy,
  input  logic            memGnt,
  input  logic [IDXW-1:0] wordIdx,
  input  logic            snapDp,
  input  logic            restDp,
  input  logic            restAct,
  output dpCtlT           ctl,
  output logic            memReq,
  output logic            memWrite,
  output logic            ldEn,
  output logic            resumeExec,
  output logic            seqBusy
);
  seqStateT state, nextState;
  logic lastWord, ackOk;

  assign memReq   = (state == ST_SAVE) || (state == ST_LOAD);
  assign memWrite = (state == ST_SAVE);
  assign seqBusy  = (state != ST_IDLE);
  assign ackOk    = memReq && memGnt && !progClr;

  always_comb begin
    if (state == ST_SAVE)
      lastWord = (wordIdx == IDXW'(snapDp ? LAST_DP : LAST_SP));
    else
      lastWord = (wordIdx == IDXW'(LAST_DP)) ||
                 ((wordIdx == IDXW'(LAST_SP)) && !restDp);
  end

  assign ldEn       = ackOk && (state == ST_LOAD);
  assign resumeExec = ldEn && lastWord && restAct;

  always_comb begin
    ctl = '0;
    nextState = state;
    ctl.step = ackOk;
    ctl.capHead = ldEn && (wordIdx == '0);
    if (progClr) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (stopReq) begin
            ctl.loadBase = 1'b1;
            ctl.snapStat = 1'b1;
            nextState = ST_WAIT;
          end else if (restartReq) begin
            ctl.loadBase = 1'b1;
            nextState = ST_LOAD;
          end
        end
        ST_WAIT: if (!arithBusy) nextState = ST_SAVE;
        ST_SAVE, ST_LOAD: if (memGnt && lastWord) nextState = ST_IDLE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R10: abort returns to idle at the next edge
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    progClr |=> !seqBusy);
  // R7: load strobes only come from acknowledged reads
  p_load_on_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    ldEn |-> (memReq && !memWrite && memGnt));
  // R9: resume only together with a load strobe
  p_resume_with_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    resumeExec |-> ldEn);
  // R1: no transfer is requested while waiting on the arithmetic unit
  p_wait_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |=> ($past(arithBusy) && !progClr |-> !memReq));
endmodule

// File: rtl/ctxSaveSeq.sv
module ctxSaveSeq
  import ctxSavePkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int HEAD_WORDS = 4,
  parameter int ACC_WORDS = 3,
  parameter int DP_BIT = 7,
  parameter int ACT_BIT = 15,
  localparam int IDXW = $clog2(HEAD_WORDS + ACC_WORDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stopReq,
  input  logic                    restartReq,
  input  logic                    progClr,
  input  logic [AW-1:0]           aData,
  input  logic                    arithBusy,
  input  logic [DW-1:0]           statusIn,
  input  logic [DW-1:0]           cmdIn,
  input  logic [DW-1:0]           indexIn,
  input  logic [DW-1:0]           pcIn,
  input  logic [DW*ACC_WORDS-1:0] accIn,
  output logic                    memReq,
  output logic                    memWrite,
  output logic [AW-1:0]           memAddr,
  output logic [DW-1:0]           memWData,
  input  logic                    memGnt,
  input  logic [DW-1:0]           memRData,
  output logic                    ldEn,
  output logic [IDXW-1:0]         ldSel,
  output logic [DW-1:0]           ldData,
  output logic                    resumeExec,
  output logic                    seqBusy
);
  localparam int LAST_DP = HEAD_WORDS + ACC_WORDS - 1;
  localparam int LAST_SP = HEAD_WORDS + ACC_WORDS - 2;

  dpCtlT ctl;
  logic [IDXW-1:0] wordIdx;
  logic snapDp, restDp, restAct;

  ctxSaveCtl #(.IDXW(IDXW), .LAST_SP(LAST_SP), .LAST_DP(LAST_DP)) uCtl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .restartReq(restartReq),
    .progClr(progClr), .arithBusy(arithBusy), .memGnt(memGnt),
    .wordIdx(wordIdx), .snapDp(snapDp), .restDp(restDp), .restAct(restAct),
    .ctl(ctl), .memReq(memReq), .memWrite(memWrite), .ldEn(ldEn),
    .resumeExec(resumeExec), .seqBusy(seqBusy)
  );

  ctxSaveData #(.AW(AW), .DW(DW), .HEAD_WORDS(HEAD_WORDS), .ACC_WORDS(ACC_WORDS),
                .DP_BIT(DP_BIT), .ACT_BIT(ACT_BIT), .IDXW(IDXW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .aData(aData), .statusIn(statusIn),
    .cmdIn(cmdIn), .indexIn(indexIn), .pcIn(pcIn), .accIn(accIn),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .wordIdx(wordIdx), .snapDp(snapDp), .restDp(restDp), .restAct(restAct)
  );

  assign ldSel  = wordIdx;
  assign ldData = memRData;

  // R6: a pending request holds its address and direction
  p_hold_request_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt && !progClr) |=>
      (memReq && $stable(memAddr) && $stable(memWrite)));
  // R6: each acknowledge advances the address by one
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt && !progClr) |=>
      (!memReq || memAddr == $past(memAddr) + 1'b1));
endmodule

// File: tb/tb_ctxSaveSeq.sv
module tb_ctxSaveSeq;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic clk = 0, rstN = 0;
  logic stopReq = 0, restartReq = 0, progClr = 0, arithBusy = 0;
  logic [15:0] aData = 0, statusIn = 0, cmdIn = 0, indexIn = 0, pcIn = 0;
  logic [47:0] accIn = 0;
  logic memReq, memWrite, memGnt = 0, ldEn, resumeExec, seqBusy;
  logic [15:0] memAddr, memWData, memRData = 0, ldData;
  logic [2:0] ldSel;

  int checks = 0, errors = 0;
  int gntLat = 0, gntCnt = 0;
  logic [15:0] mem [0:63];
  int wCount = 0, ldCount = 0, resumeCnt = 0, resumeSel = -1, reqWhileArith = 0;
  logic [15:0] wAddr [0:15];
  logic [15:0] wData [0:15];
  logic [2:0]  lSel  [0:15];
  logic [15:0] lData [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctxSaveSeq dut (.*);

  // memory responder
  always @(negedge clk) begin
    if (memGnt || !memReq) begin
      memGnt <= 1'b0;
      gntCnt <= 0;
    end else if (gntCnt >= gntLat) begin
      memGnt <= 1'b1;
      memRData <= mem[memAddr[5:0]];
      if (memWrite) mem[memAddr[5:0]] <= memWData;
    end else begin
      gntCnt <= gntCnt + 1;
    end
  end

  // monitor, sampled a quarter period after the falling edge
  always begin
    @(negedge clk); #(Q);
    if (memReq && arithBusy) reqWhileArith++;
    if (memReq && memGnt && memWrite && wCount < 16) begin
      wAddr[wCount] = memAddr; wData[wCount] = memWData; wCount++;
    end
    if (ldEn && ldCount < 16) begin
      lSel[ldCount] = ldSel; lData[ldCount] = ldData; ldCount++;
    end
    if (resumeExec) begin resumeCnt++; resumeSel = ldCount - 1; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    wCount = 0; ldCount = 0; resumeCnt = 0; resumeSel = -1; reqWhileArith = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #(Q);
      if (!seqBusy) break;
    end
  endtask

  task automatic testReset();
    check(seqBusy == 0, "R5", "busy after reset", seqBusy, 0);
    check(memReq == 0, "R5", "req after reset", memReq, 0);
    check(resumeExec == 0, "R9", "resume after reset", resumeExec, 0);
  endtask

  task automatic doStop(input logic [15:0] base, input logic [15:0] stat,
                        input int busyN, input int lat, input bit poke);
    logic [15:0] exp [0:6];
    int n;
    clearLogs();
    gntLat = lat;
    exp[0] = stat; exp[1] = 16'h3C01; exp[2] = 16'h0042; exp[3] = 16'h1234;
    exp[4] = 16'h5A5A; exp[5] = 16'hC3C3; exp[6] = 16'h0F0F;
    n = stat[7] ? 7 : 6;
    @(negedge clk);
    statusIn = stat; cmdIn = exp[1]; indexIn = exp[2]; pcIn = exp[3];
    accIn = {exp[6], exp[5], exp[4]};
    arithBusy = (busyN > 0); stopReq = 1; aData = base;
    @(negedge clk);
    stopReq = 0; aData = 16'h0030;
    statusIn = stat ^ 16'h8010;  // later changes must not reach the record
    #(Q);
    check(seqBusy == 1, "R5", "busy after stop", seqBusy, 1);
    if (poke) begin
      @(negedge clk); restartReq = 1; stopReq = 1;
      @(negedge clk); restartReq = 0; stopReq = 0;
    end
    for (int i = 0; i < busyN; i++) @(negedge clk);
    arithBusy = 0;
    waitIdle();
    check(reqWhileArith == 0, "R1", "request during arithmetic", reqWhileArith, 0);
    check(wCount == n, "R3", "words written", wCount, n);
    for (int i = 0; i < n && i < wCount; i++) begin
      check(wAddr[i] == base + 16'(i), "R6", "write address", wAddr[i], base + 16'(i));
      check(wData[i] == exp[i], (i == 0) ? "R4" : "R2", "write data", wData[i], exp[i]);
    end
    check(seqBusy == 0, "R5", "busy after save", seqBusy, 0);
    if (poke) check(ldCount == 0, "R11", "loads from ignored restart", ldCount, 0);
  endtask

  task automatic doRestart(input logic [15:0] base, input logic [15:0] stat,
                           input int lat);
    int n;
    clearLogs();
    gntLat = lat;
    n = stat[7] ? 7 : 6;
    mem[base[5:0]] = stat;
    for (int i = 1; i < 8; i++) mem[6'(base + 16'(i))] = 16'hA000 + 16'(i);
    @(negedge clk); restartReq = 1; aData = base;
    @(negedge clk); restartReq = 0; aData = 0; #(Q);
    check(seqBusy == 1, "R5", "busy after restart", seqBusy, 1);
    waitIdle();
    check(ldCount == n, "R8", "words restored", ldCount, n);
    for (int i = 0; i < n && i < ldCount; i++) begin
      check(lSel[i] == 3'(i), "R7", "load select", lSel[i], i);
      check(lData[i] == ((i == 0) ? stat : 16'hA000 + 16'(i)), "R7", "load data",
            lData[i], (i == 0) ? stat : 16'hA000 + 16'(i));
    end
    check(resumeCnt == int'(stat[15]), "R9", "resume count", resumeCnt, stat[15]);
    if (stat[15]) check(resumeSel == n - 1, "R9", "resume on last word", resumeSel, n - 1);
    check(wCount == 0, "R7", "writes during restore", wCount, 0);
  endtask

  task automatic doAbort();
    clearLogs();
    gntLat = 3;
    mem[20] = 16'h8080;
    @(negedge clk); restartReq = 1; aData = 16'd20;
    @(negedge clk); restartReq = 0;
    for (int i = 0; i < 100 && ldCount < 2; i++) begin @(negedge clk); #(Q); end
    @(negedge clk); progClr = 1;
    @(negedge clk); progClr = 0; #(Q);
    check(seqBusy == 0, "R10", "busy after clear", seqBusy, 0);
    check(memReq == 0, "R10", "req after clear", memReq, 0);
    repeat (12) @(negedge clk);
    #(Q);
    check(ldCount == 2, "R10", "loads after clear", ldCount, 2);
    check(resumeCnt == 0, "R10", "resume after clear", resumeCnt, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    #(Q);
    testReset();
    rstN = 1;
    @(negedge clk);
    doStop(16'd4, 16'h0010, 4, 0, 0);   // single precision, idle stop, protect set
    doStop(16'd16, 16'h8090, 2, 2, 0);  // double precision, active
    doStop(16'd40, 16'h0080, 3, 1, 1);  // requests during save ignored
    doRestart(16'd4, 16'h0010, 0);
    doRestart(16'd24, 16'h8090, 2);
    doRestart(16'd50, 16'h8000, 1);
    doAbort();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule